// File: doc/BRIEF.md
# Clock Lane Burst Sequencer

This block steps the clock lane of a source-synchronous serial link from its low-power idle into a high-speed burst and back to idle. It drives a two-bit low-power line level together with a high-speed enable and a clock-toggle enable. Every phase of the sequence lasts a set number of reference-clock cycles, and each count comes from a configuration input. The conversion from physical time to cycle counts is done outside the block, as are the analog drivers and the serializer.

A burst starts when `start_req` is seen while the lane is idle and the configuration is legal. The lane then steps through these phases in order:

1. A request level.
2. A prepare interval at the both-low level.
3. A high-speed zero interval with no toggling.
4. A pre interval of toggling.

After the pre interval, `clk_ready` tells the data lane sequencer that it may begin. The clock keeps toggling until `data_done` reports that the data lane has gone back to low power. The block then runs these phases before it returns to idle:

1. A post interval of toggling.
2. A trail interval at the high-speed zero level.
3. An exit interval at the stop level.

`busy` marks the whole burst. It tells upstream logic when a new request will be accepted. The block copies all interval counts when a burst starts, so the host may reprogram the configuration at any time.

Top module: `clk_lane_seq`

## Requirements
- R1: After reset the lane idles: `lp_state` = 2'b11 (bit 1 = positive line, bit 0 = negative line), and `hs_en`, `hs_clk_on`, `clk_ready` and `busy` are all 0.
- R2: The block samples `start_req` = 1 while idle with a legal configuration. From the next cycle it drives `lp_state` = 2'b01 with `busy` = 1 for `cfg_lpx` cycles.
- R3: Next it drives `lp_state` = 2'b00 with `hs_en` = 0 for `cfg_prep` cycles.
- R4: Next it drives `hs_en` = 1 with `hs_clk_on` = 0 for `cfg_zero` cycles. `hs_en` only rises from the both-low level.
- R5: Next `hs_clk_on` = 1 with `clk_ready` = 0 for `cfg_pre` cycles. After that, `clk_ready` = 1 while toggling, until the cycle after `data_done` is sampled high.
- R6: After `data_done` it toggles with `clk_ready` = 0 for `cfg_post` cycles.
- R7: Next it drives `hs_en` = 1 with `hs_clk_on` = 0 for `cfg_trail` cycles.
- R8: Next it drives `lp_state` = 2'b11 with `busy` = 1 for `cfg_exit` cycles, and then returns to the idle state of R1.
- R9: The configuration is illegal when `cfg_prep` is outside [`prep_min`, `prep_max`], when `cfg_pre` < MIN_PRE, or when any interval count is zero. An illegal configuration sets `cfg_err` one cycle later, and `start_req` is then ignored.
- R10: `start_req` while `busy` = 1 is ignored. No second burst follows.
- R11: Interval counts are captured when a burst starts. Changing the configuration inputs during a burst does not alter that burst.
- R12: While `hs_en` = 1, `lp_state` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to start a burst |
| data_done | input | 1 | Data lane has returned to low power |
| cfg_lpx | input | CW | Request-level length in cycles |
| cfg_prep | input | CW | Prepare length in cycles |
| cfg_zero | input | CW | High-speed zero length before toggling |
| cfg_pre | input | CW | Toggling cycles before `clk_ready` |
| cfg_post | input | CW | Toggling cycles after `data_done` |
| cfg_trail | input | CW | High-speed zero length after toggling |
| cfg_exit | input | CW | Stop-level length before idle |
| prep_min | input | CW | Lowest legal prepare count |
| prep_max | input | CW | Highest legal prepare count |
| lp_state | output | 2 | Low-power line level {positive, negative} |
| hs_en | output | 1 | High-speed driver enable |
| hs_clk_on | output | 1 | Clock toggling enable |
| clk_ready | output | 1 | Data lane may start |
| busy | output | 1 | Burst in progress |
| cfg_err | output | 1 | Configuration is illegal |

## Verification
The bench builds the block with CW = 6 and MIN_PRE = 3. The narrow counters keep every interval short, so many bursts fit in a short run. The small pre floor lets the bench reach both sides of it, one below the floor and one exactly at it. The prepare window is fixed at [3, 7]. This brings the window edges within reach as directed cases, along with all-minimum counts and a one-cycle data phase. Random legal bursts then mix counts, which exercises every phase length against a per-phase measurement taken at the ports.

// File: rtl/clk_lane_seq_pkg.sv
package clk_lane_seq_pkg;
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_REQ,
    PH_PREP,
    PH_ZERO,
    PH_PRE,
    PH_RUN,
    PH_POST,
    PH_TRAIL,
    PH_EXIT
  } phase_t;
endpackage

// File: rtl/clk_lane_seq_cfg_check.sv
module clk_lane_seq_cfg_check #(
  parameter int CW      = 8,
  parameter int MIN_PRE = 4
) (
  input  logic [CW-1:0] lpx,
  input  logic [CW-1:0] prep,
  input  logic [CW-1:0] zero,
  input  logic [CW-1:0] pre,
  input  logic [CW-1:0] post,
  input  logic [CW-1:0] trail,
  input  logic [CW-1:0] ext,
  input  logic [CW-1:0] win_lo,
  input  logic [CW-1:0] win_hi,
  output logic          bad
);
  localparam logic [CW-1:0] PRE_FLOOR = CW'(MIN_PRE);
  logic any_zero;
  logic out_window;

  always_comb begin
    any_zero   = (lpx == '0) || (prep == '0) || (zero == '0) || (pre == '0)
              || (post == '0) || (trail == '0) || (ext == '0);
    out_window = (prep < win_lo) || (prep > win_hi);
    bad        = any_zero || out_window || (pre < PRE_FLOOR);
  end
endmodule

// File: rtl/clk_lane_seq_timer.sv
module clk_lane_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R2..R8: interval lengths rely on a steady one-per-cycle countdown
  assert_timer_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/clk_lane_seq.sv
module clk_lane_seq #(
  parameter int CW      = 8,
  parameter int MIN_PRE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          data_done,
  input  logic [CW-1:0] cfg_lpx,
  input  logic [CW-1:0] cfg_prep,
  input  logic [CW-1:0] cfg_zero,
  input  logic [CW-1:0] cfg_pre,
  input  logic [CW-1:0] cfg_post,
  input  logic [CW-1:0] cfg_trail,
  input  logic [CW-1:0] cfg_exit,
  input  logic [CW-1:0] prep_min,
  input  logic [CW-1:0] prep_max,
  output logic [1:0]    lp_state,
  output logic          hs_en,
  output logic          hs_clk_on,
  output logic          clk_ready,
  output logic          busy,
  output logic          cfg_err
);
  import clk_lane_seq_pkg::*;

  localparam logic [CW-1:0] ONE = CW'(1);

  phase_t        ph, ph_nxt;
  logic          illegal;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_done;
  logic [CW-1:0] sh_prep, sh_zero, sh_pre, sh_post, sh_trail, sh_exit;
  logic          launch;

  clk_lane_seq_cfg_check #(.CW(CW), .MIN_PRE(MIN_PRE)) u_check (
    .lpx(cfg_lpx), .prep(cfg_prep), .zero(cfg_zero), .pre(cfg_pre),
    .post(cfg_post), .trail(cfg_trail), .ext(cfg_exit),
    .win_lo(prep_min), .win_hi(prep_max), .bad(illegal)
  );

  clk_lane_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_done)
  );

  assign launch = (ph == PH_IDLE) && start_req && !illegal;

  always_comb begin
    ph_nxt   = ph;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (ph)
      PH_IDLE:  if (launch)    begin ph_nxt = PH_REQ;   tmr_load = 1'b1; tmr_val = cfg_lpx - ONE;  end
      PH_REQ:   if (tmr_done)  begin ph_nxt = PH_PREP;  tmr_load = 1'b1; tmr_val = sh_prep - ONE;  end
      PH_PREP:  if (tmr_done)  begin ph_nxt = PH_ZERO;  tmr_load = 1'b1; tmr_val = sh_zero - ONE;  end
      PH_ZERO:  if (tmr_done)  begin ph_nxt = PH_PRE;   tmr_load = 1'b1; tmr_val = sh_pre - ONE;   end
      PH_PRE:   if (tmr_done)  ph_nxt = PH_RUN;
      PH_RUN:   if (data_done) begin ph_nxt = PH_POST;  tmr_load = 1'b1; tmr_val = sh_post - ONE;  end
      PH_POST:  if (tmr_done)  begin ph_nxt = PH_TRAIL; tmr_load = 1'b1; tmr_val = sh_trail - ONE; end
      PH_TRAIL: if (tmr_done)  begin ph_nxt = PH_EXIT;  tmr_load = 1'b1; tmr_val = sh_exit - ONE;  end
      PH_EXIT:  if (tmr_done)  ph_nxt = PH_IDLE;
      default:  ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      cfg_err  <= 1'b0;
      sh_prep  <= '0;
      sh_zero  <= '0;
      sh_pre   <= '0;
      sh_post  <= '0;
      sh_trail <= '0;
      sh_exit  <= '0;
    end else begin
      ph      <= ph_nxt;
      cfg_err <= illegal;
      if (launch) begin
        sh_prep  <= cfg_prep;
        sh_zero  <= cfg_zero;
        sh_pre   <= cfg_pre;
        sh_post  <= cfg_post;
        sh_trail <= cfg_trail;
        sh_exit  <= cfg_exit;
      end
    end
  end

  always_comb begin
    case (ph)
      PH_IDLE, PH_EXIT: lp_state = 2'b11;
      PH_REQ:           lp_state = 2'b01;
      default:          lp_state = 2'b00;
    endcase
    hs_en     = (ph == PH_ZERO) || (ph == PH_PRE) || (ph == PH_RUN)
             || (ph == PH_POST) || (ph == PH_TRAIL);
    hs_clk_on = (ph == PH_PRE) || (ph == PH_RUN) || (ph == PH_POST);
    clk_ready = (ph == PH_RUN);
    busy      = (ph != PH_IDLE);
  end

  assert_hs_lp_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> (lp_state == 2'b00));

  assert_hs_from_prep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ($past(lp_state) == 2'b00));

  assert_ready_toggling_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ready |-> (hs_clk_on && hs_en));

  assert_start_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start_req) && !$past(illegal)));

  assert_end_at_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(lp_state) == 2'b11 && !$past(hs_en)));

  assert_snapshot_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(sh_prep) && $stable(sh_post) && $stable(sh_exit)));
endmodule

// File: tb/clk_lane_seq_bench.sv
module clk_lane_seq_bench;
  localparam int CW      = 6;
  localparam int MIN_PRE = 3;
  localparam int PERIOD  = 10;
  localparam int PMIN    = 3;
  localparam int PMAX    = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_req = 1'b0;
  logic          data_done = 1'b0;
  logic [CW-1:0] c_lpx, c_prep, c_zero, c_pre, c_post, c_trail, c_exit;
  logic [CW-1:0] p_lo, p_hi;
  logic [1:0]    lp_state;
  logic          hs_en, hs_clk_on, clk_ready, busy, cfg_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  clk_lane_seq #(.CW(CW), .MIN_PRE(MIN_PRE)) u_clk_lane_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .data_done(data_done),
    .cfg_lpx(c_lpx), .cfg_prep(c_prep), .cfg_zero(c_zero), .cfg_pre(c_pre),
    .cfg_post(c_post), .cfg_trail(c_trail), .cfg_exit(c_exit),
    .prep_min(p_lo), .prep_max(p_hi),
    .lp_state(lp_state), .hs_en(hs_en), .hs_clk_on(hs_clk_on),
    .clk_ready(clk_ready), .busy(busy), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // phase code seen at the ports: 0 idle,1 req,2 prep,3 hs-zero,4 toggling,5 ready,8 exit,9 other
  function automatic int code_of(input logic [1:0] lp, input logic hs, input logic tg,
                                 input logic rd, input logic bs);
    if (!bs) return 0;
    if (!hs && lp == 2'b01) return 1;
    if (!hs && lp == 2'b00) return 2;
    if (!hs && lp == 2'b11) return 8;
    if (hs && !tg) return 3;
    if (hs && tg && rd) return 5;
    if (hs && tg) return 4;
    return 9;
  endfunction

  task automatic set_cfg(input int l, input int p, input int z, input int pr,
                         input int po, input int tr, input int ex);
    c_lpx = CW'(l); c_prep = CW'(p); c_zero = CW'(z); c_pre = CW'(pr);
    c_post = CW'(po); c_trail = CW'(tr); c_exit = CW'(ex);
  endtask

  task automatic burst(input int l, input int p, input int z, input int pr,
                       input int po, input int tr, input int ex,
                       input int run_len, input bit poke, input bit mid_change);
    int seg_code[16];
    int seg_len[16];
    int exp_code[8] = '{1, 2, 3, 4, 5, 4, 3, 8};
    int exp_len[8];
    string tags[8] = '{"R2", "R3", "R4", "R5", "R5", "R6", "R7", "R8"};
    int nseg = 0;
    int cur = -1;
    int len = 0;
    int rc = 0;
    int guard = 0;
    int hs_viol = 0;
    int cd;
    exp_len = '{l, p, z, pr, run_len, po, tr, ex};
    @(negedge clk);
    set_cfg(l, p, z, pr, po, tr, ex);
    repeat (2) @(negedge clk);
    chk(cfg_err == 1'b0, "R9 legal cfg no error", int'(cfg_err), 0);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    while (guard < 2000) begin
      cd = code_of(lp_state, hs_en, hs_clk_on, clk_ready, busy);
      if (hs_en && lp_state != 2'b00) hs_viol++;
      start_req = 1'b0;
      if (cd == 5) begin
        rc++;
        data_done = (rc == run_len);
        if (poke && rc == 2) start_req = 1'b1;
        if (mid_change && rc == 1) set_cfg(l + 1, PMAX + 2, z + 3, pr + 2, po + 2, tr + 1, ex + 2);
      end else begin
        data_done = 1'b0;
      end
      if (cd != cur) begin
        if (cur != -1 && nseg < 16) begin
          seg_code[nseg] = cur;
          seg_len[nseg] = len;
          nseg++;
        end
        cur = cd;
        len = 1;
      end else begin
        len++;
      end
      if (cd == 0) break;
      @(negedge clk);
      guard++;
    end
    data_done = 1'b0;
    start_req = 1'b0;
    chk(nseg == 8, "R2 phase count", nseg, 8);
    for (int i = 0; i < 8 && i < nseg; i++) begin
      chk(seg_code[i] == exp_code[i], {tags[i], " phase order"}, seg_code[i], exp_code[i]);
      chk(seg_len[i] == exp_len[i],
          mid_change ? {tags[i], " R11 length after cfg change"} : {tags[i], " phase length"},
          seg_len[i], exp_len[i]);
    end
    chk(hs_viol == 0, "R12 lp low during hs", hs_viol, 0);
    chk(lp_state == 2'b11 && !hs_en && !clk_ready, "R8 idle after exit", int'(lp_state), 3);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, poke ? "R10 start during burst ignored" : "R8 stays idle", int'(busy), 0);
  endtask

  task automatic try_bad(input int l, input int p, input int z, input int pr,
                         input int po, input int tr, input int ex, input string why);
    @(negedge clk);
    set_cfg(l, p, z, pr, po, tr, ex);
    repeat (2) @(negedge clk);
    chk(cfg_err == 1'b1, {"R9 error flag ", why}, int'(cfg_err), 1);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && lp_state == 2'b11, {"R9 start blocked ", why}, int'(busy), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int seed_init;
    seed_init = $urandom(32'd20240);
    p_lo = CW'(PMIN);
    p_hi = CW'(PMAX);
    set_cfg(1, PMIN, 1, MIN_PRE, 1, 1, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lp_state == 2'b11 && !hs_en && !hs_clk_on && !clk_ready && !busy,
        "R1 reset idle", int'(lp_state), 3);
    chk(cfg_err == 1'b0, "R1 no error after reset", int'(cfg_err), 0);

    burst(1, PMIN, 1, MIN_PRE, 1, 1, 1, 1, 1'b0, 1'b0);
    burst(2, PMAX, 3, MIN_PRE + 2, 4, 2, 3, 5, 1'b1, 1'b0);
    burst(3, 5, 2, MIN_PRE + 1, 3, 3, 2, 4, 1'b0, 1'b1);

    try_bad(1, PMIN - 1, 1, MIN_PRE, 1, 1, 1, "prep below window");
    try_bad(1, PMAX + 1, 1, MIN_PRE, 1, 1, 1, "prep above window");
    try_bad(1, PMIN, 1, MIN_PRE - 1, 1, 1, 1, "pre below floor");
    try_bad(1, PMIN, 1, MIN_PRE, 1, 0, 1, "zero trail");
    try_bad(0, PMIN, 1, MIN_PRE, 1, 1, 1, "zero lpx");

    for (int k = 0; k < 20; k++) begin
      burst(1 + int'($urandom % 3), PMIN + int'($urandom % (PMAX - PMIN + 1)),
            1 + int'($urandom % 5), MIN_PRE + int'($urandom % 5),
            1 + int'($urandom % 6), 1 + int'($urandom % 4), 1 + int'($urandom % 4),
            3 + int'($urandom % 4), ($urandom % 2) == 1, ($urandom % 3) == 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule